// File: doc/BRIEF.md
# Streaming Two-Operand Pixel ALU

This block is a per-pixel arithmetic stage for an image pipeline. It takes a primary pixel stream A and a second operand. The second operand comes either from a secondary stream B or from a programmable constant pixel. Each accepted transfer produces one result pixel. The block merges the outputs of parallel neighbourhood operators, for example by taking the minimum, maximum or absolute difference of two images. It also performs point operations on one image against the constant, such as thresholding or conditional replacement.

The operation is chosen by a 4-bit opcode, an operand-source select and a 2-bit compare mode. All three are sampled together with the data on the cycle a transfer is accepted. Stream A is always consumed. Stream B is consumed only when the selected operation needs it and the source select points at the stream.

The result sits in a single output register. That register is driven by a two-state machine:
- **EMPTY**: no result is held.
- **FULL**: a result is held.

The transitions between the states are:
- **LOAD**: EMPTY to FULL, when a transfer is accepted.
- **REFILL**: FULL to FULL, when the result is taken and a new transfer is accepted in the same cycle.
- **HOLD**: FULL to FULL, when the downstream stalls.
- **DRAIN**: FULL to EMPTY, when the result is taken and nothing new is accepted.

Top module: `pxalu_top`

## Requirements
- R1: After reset, `out_valid` is 0. A transfer accepted on a clock edge (`a_ready` high) sets `out_valid` at that edge, so the result appears one cycle later. If the result is taken with no new transfer accepted, `out_valid` returns to 0.
- R2: A transfer is accepted only when A is valid, and also B is valid whenever B is needed. While a needed B is absent, neither `a_ready` nor `b_ready` is raised. When B is needed, `a_ready` and `b_ready` rise together.
- R3: Opcode 2 (ADD) gives (A+S) mod 256. Opcode 3 (SUB) gives (A-S) mod 256. S is the second operand.
- R4: Opcode 4 (saturating add) gives min(A+S, 255). Opcode 5 (saturating subtract) gives max(A-S, 0).
- R5: Opcode 6 gives |A-S|. Opcode 7 gives min(A,S). Opcode 8 gives max(A,S).
- R6: When `src_sel` is 1, S is `const_px` and B is never consumed (`b_ready` stays 0). When `src_sel` is 0, S is `b_data`.
- R7: Opcode 0 copies A and does not consume B. Opcode 1 copies S.
- R8: Opcode 9 (compare-select) tests A against S. The test is A>S for `cmp_mode` 0, A<S for 1, A==S for 2, and never true for 3. The output is `const_px` when the test is true and A otherwise.
- R9: Opcode 10 (threshold) gives 255 when A > `const_px` and 0 otherwise. It never consumes B.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value and no transfer is accepted.
- R11: Reserved opcodes 11 to 15 act as opcode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Stream A has a pixel |
| a_data | input | 8 | Stream A pixel |
| a_ready | output | 1 | Stream A pixel accepted this cycle |
| b_valid | input | 1 | Stream B has a pixel |
| b_data | input | 8 | Stream B pixel |
| b_ready | output | 1 | Stream B pixel accepted this cycle |
| op_code | input | 4 | Operation select |
| src_sel | input | 1 | 0: second operand from B, 1: from constant |
| cmp_mode | input | 2 | Compare condition for compare-select |
| const_px | input | 8 | Constant pixel |
| out_valid | output | 1 | Result pixel present |
| out_data | output | 8 | Result pixel |
| out_ready | input | 1 | Downstream takes the result |

## Verification
The assertions assume that the opcode, source select, compare mode and constant are meaningful only in the cycle a transfer is accepted. They also assume that upstream valid signals may drop at any time without a protocol violation. The properties sample every control input together with the data at the accepting edge, so they hold even when the controls change freely between transfers. The stimulus changes all inputs only on the falling edge. A full sweep of A values is run for every opcode, both operand sources and every compare mode. Stall phases are added that withhold B, withhold the downstream, or drop A.

// File: rtl/pxalu_pkg.sv
package pxalu_pkg;

    typedef enum logic [3:0] {
        OP_PASS_A = 4'd0,
        OP_PASS_S = 4'd1,
        OP_ADD    = 4'd2,
        OP_SUB    = 4'd3,
        OP_ADDS   = 4'd4,
        OP_SUBS   = 4'd5,
        OP_ABSD   = 4'd6,
        OP_MIN    = 4'd7,
        OP_MAX    = 4'd8,
        OP_CSEL   = 4'd9,
        OP_THR    = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        CMP_GT   = 2'd0,
        CMP_LT   = 2'd1,
        CMP_EQ   = 2'd2,
        CMP_NONE = 2'd3
    } cmp_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } ost_e;

endpackage

// File: rtl/pxalu_operand.sv
module pxalu_operand
    import pxalu_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int OP_W  = 4
) (
    input  logic [OP_W-1:0]  op_code,
    input  logic             src_sel,
    input  logic [PIX_W-1:0] b_data,
    input  logic [PIX_W-1:0] const_px,
    output logic [PIX_W-1:0] opnd,
    output logic             need_b
);

    logic uses_second;

    always_comb begin
        unique case (op_code)
            OP_PASS_S, OP_ADD, OP_SUB, OP_ADDS, OP_SUBS,
            OP_ABSD, OP_MIN, OP_MAX, OP_CSEL: uses_second = 1'b1;
            default:                          uses_second = 1'b0;
        endcase
    end

    assign opnd   = src_sel ? const_px : b_data;
    assign need_b = uses_second && !src_sel;

endmodule

// File: rtl/pxalu_core.sv
module pxalu_core
    import pxalu_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int OP_W  = 4
) (
    input  logic [OP_W-1:0]  op_code,
    input  logic [1:0]       cmp_mode,
    input  logic [PIX_W-1:0] a_px,
    input  logic [PIX_W-1:0] s_px,
    input  logic [PIX_W-1:0] const_px,
    output logic [PIX_W-1:0] result
);

    localparam logic [PIX_W-1:0] PIX_MAX  = {PIX_W{1'b1}};
    localparam logic [PIX_W-1:0] PIX_ZERO = '0;

    logic [PIX_W:0]   sum_x;
    logic [PIX_W:0]   dif_x;
    logic             carry;
    logic             borrow;
    logic [PIX_W-1:0] abs_d;
    logic             a_gt_s;
    logic             a_lt_s;
    logic             a_eq_s;
    logic             cond;

    assign sum_x  = {1'b0, a_px} + {1'b0, s_px};
    assign dif_x  = {1'b0, a_px} - {1'b0, s_px};
    assign carry  = sum_x[PIX_W];
    assign borrow = dif_x[PIX_W];
    assign abs_d  = borrow ? (s_px - a_px) : dif_x[PIX_W-1:0];
    assign a_gt_s = !borrow && (dif_x[PIX_W-1:0] != PIX_ZERO);
    assign a_lt_s = borrow;
    assign a_eq_s = (a_px == s_px);

    always_comb begin
        unique case (cmp_mode)
            CMP_GT:  cond = a_gt_s;
            CMP_LT:  cond = a_lt_s;
            CMP_EQ:  cond = a_eq_s;
            default: cond = 1'b0;
        endcase
    end

    always_comb begin
        unique case (op_code)
            OP_PASS_S: result = s_px;
            OP_ADD:    result = sum_x[PIX_W-1:0];
            OP_SUB:    result = dif_x[PIX_W-1:0];
            OP_ADDS:   result = carry ? PIX_MAX : sum_x[PIX_W-1:0];
            OP_SUBS:   result = borrow ? PIX_ZERO : dif_x[PIX_W-1:0];
            OP_ABSD:   result = abs_d;
            OP_MIN:    result = borrow ? a_px : s_px;
            OP_MAX:    result = borrow ? s_px : a_px;
            OP_CSEL:   result = cond ? const_px : a_px;
            OP_THR:    result = (a_px > const_px) ? PIX_MAX : PIX_ZERO;
            default:   result = a_px;
        endcase
    end

endmodule

// File: rtl/pxalu_outreg.sv
module pxalu_outreg
    import pxalu_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_ok,
    input  logic [PIX_W-1:0] nxt_data,
    input  logic             out_ready,
    output logic             take,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data
);

    ost_e state_q;
    ost_e state_d;

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                take = in_ok;
                if (in_ok) state_d = ST_FULL;            // LOAD
            end
            ST_FULL: begin
                take = in_ok && out_ready;
                if (out_ready && !in_ok) state_d = ST_EMPTY; // DRAIN
                else                     state_d = ST_FULL;  // REFILL / HOLD
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    out_data <= '0;
        else if (take) out_data <= nxt_data;
    end

    assign out_valid = (state_q == ST_FULL);

    // R10: a stalled result stays put
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10: no transfer accepted into a stalled register
    p_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !take);

endmodule

// File: rtl/pxalu_top.sv
module pxalu_top
    import pxalu_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int OP_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_valid,
    input  logic [PIX_W-1:0] a_data,
    output logic             a_ready,
    input  logic             b_valid,
    input  logic [PIX_W-1:0] b_data,
    output logic             b_ready,
    input  logic [OP_W-1:0]  op_code,
    input  logic             src_sel,
    input  logic [1:0]       cmp_mode,
    input  logic [PIX_W-1:0] const_px,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data,
    input  logic             out_ready
);

    localparam logic [PIX_W-1:0] PIX_MAX = {PIX_W{1'b1}};

    logic [PIX_W-1:0] s_px;
    logic             need_b;
    logic [PIX_W-1:0] res;
    logic             in_ok;
    logic             take;

    pxalu_operand #(.PIX_W(PIX_W), .OP_W(OP_W)) u_opnd (
        .op_code  (op_code),
        .src_sel  (src_sel),
        .b_data   (b_data),
        .const_px (const_px),
        .opnd     (s_px),
        .need_b   (need_b)
    );

    pxalu_core #(.PIX_W(PIX_W), .OP_W(OP_W)) u_core (
        .op_code  (op_code),
        .cmp_mode (cmp_mode),
        .a_px     (a_data),
        .s_px     (s_px),
        .const_px (const_px),
        .result   (res)
    );

    assign in_ok = a_valid && (!need_b || b_valid);

    pxalu_outreg #(.PIX_W(PIX_W)) u_oreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_ok     (in_ok),
        .nxt_data  (res),
        .out_ready (out_ready),
        .take      (take),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign a_ready = take;
    assign b_ready = take && need_b;

    // R1: accepted transfer yields a result next cycle
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        a_ready |=> out_valid);

    // R2: no acceptance without the data it needs
    p_join_r2: assert property (@(posedge clk) disable iff (!rst_n)
        b_ready |-> (a_ready && a_valid && b_valid));

    p_a_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        a_ready |-> a_valid);

    // R4: saturating add never falls below A
    p_sat_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ready && op_code == OP_ADDS) |=> (out_data >= $past(a_data)));

    // R5: minimum never exceeds A
    p_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ready && op_code == OP_MIN) |=> (out_data <= $past(a_data)));

    // R6: constant source never consumes B
    p_const_no_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel |-> !b_ready);

    // R9: threshold output is one of two levels
    p_thr_levels_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ready && op_code == OP_THR) |=> (out_data == '0 || out_data == PIX_MAX));

endmodule

// File: tb/sim_pxalu_top.sv
module sim_pxalu_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       a_valid, b_valid, out_ready, src_sel;
    logic [7:0] a_data, b_data, const_px;
    logic [3:0] op_code;
    logic [1:0] cmp_mode;
    logic       a_ready, b_ready, out_valid;
    logic [7:0] out_data;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #2 clk = ~clk;

    pxalu_top u0 (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
        .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready),
        .op_code(op_code), .src_sel(src_sel), .cmp_mode(cmp_mode),
        .const_px(const_px),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model(int op, int sel, int cm, int c, int a, int b);
        int s = sel ? c : b;
        bit t;
        case (op)
            1:  return s;
            2:  return (a + s) % 256;
            3:  return (a - s + 256) % 256;
            4:  return (a + s > 255) ? 255 : a + s;
            5:  return (a > s) ? a - s : 0;
            6:  return (a > s) ? a - s : s - a;
            7:  return (a < s) ? a : s;
            8:  return (a > s) ? a : s;
            9: begin
                t = (cm == 0) ? (a > s) : (cm == 1) ? (a < s) : (cm == 2) ? (a == s) : 1'b0;
                return t ? c : a;
            end
            10: return (a > c) ? 255 : 0;
            default: return a;
        endcase
    endfunction

    function automatic bit uses_b(int op, int sel);
        return (sel == 0) && (op >= 1) && (op <= 9);
    endfunction

    function automatic string tag(int op, int sel);
        if (op >= 11)               return "R11";
        if (op == 0 || op == 1)     return "R7";
        if (op == 2 || op == 3)     return "R3";
        if (op == 4 || op == 5)     return "R4";
        if (op >= 6 && op <= 8)     return "R5";
        if (op == 9)                return "R8";
        if (op == 10)               return "R9";
        return sel ? "R6" : "R6";
    endfunction

    task automatic vec(int op, int sel, int cm, int c, int a, int b);
        int e;
        op_code = op[3:0]; src_sel = sel[0]; cmp_mode = cm[1:0];
        const_px = c[7:0]; a_data = a[7:0]; b_data = b[7:0];
        a_valid = 1'b1; b_valid = 1'b1; out_ready = 1'b1;
        #1;
        chk(b_ready == uses_b(op, sel), sel ? "R6" : "R2", b_ready, uses_b(op, sel));
        e = model(op, sel, cm, c, a, b);
        @(posedge clk);
        @(negedge clk);
        chk(out_valid && out_data == e[7:0], tag(op, sel), out_data, e);
    endtask

    initial begin
        rst_n = 1'b0; a_valid = 0; b_valid = 0; out_ready = 0; src_sel = 0;
        a_data = 0; b_data = 0; const_px = 0; op_code = 0; cmp_mode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(out_valid == 0, "R1 reset", out_valid, 0);

        // sweep of all A values for every opcode / source / compare mode
        for (int op = 0; op < 16; op++)
            for (int sel = 0; sel < 2; sel++)
                for (int cm = 0; cm < ((op == 9) ? 4 : 1); cm++)
                    for (int i = 0; i < 256; i++) begin
                        int b = (i % 16 == 0) ? i : (i * 53 + op * 7 + cm) % 256;
                        int c = (sel == 1 && i % 16 == 0) ? i : (op * 29 + sel * 100 + 17) % 256;
                        vec(op, sel, cm, c, i, b);
                    end

        // corner values
        vec(4, 0, 0, 0, 255, 1);   // R4 clamp high
        vec(5, 0, 0, 0, 0, 255);   // R4 clamp low
        vec(2, 0, 0, 0, 200, 100); // R3 wrap
        vec(3, 0, 0, 0, 5, 10);    // R3 wrap
        vec(10, 0, 0, 255, 255, 0); // R9 equal to constant -> 0

        // R2: missing B stalls a two-stream operation
        op_code = 4'd2; src_sel = 0; a_data = 8'd40; b_data = 8'd2;
        a_valid = 1; b_valid = 0; out_ready = 1;
        #1;
        chk(a_ready == 0 && b_ready == 0, "R2 stall", {a_ready, b_ready}, 0);
        @(posedge clk); @(negedge clk);
        chk(out_valid == 0, "R1 drain", out_valid, 0);
        b_valid = 1;
        #1;
        chk(a_ready == 1 && b_ready == 1, "R2 join", {a_ready, b_ready}, 3);
        @(posedge clk); @(negedge clk);
        chk(out_valid && out_data == 8'd42, "R2 result", out_data, 42);

        // R7: copy A needs no B
        op_code = 4'd0; a_data = 8'd77; b_valid = 0;
        #1;
        chk(a_ready == 1 && b_ready == 0, "R7 no B", {a_ready, b_ready}, 2);
        @(posedge clk); @(negedge clk);
        chk(out_data == 8'd77, "R7 copy", out_data, 77);

        // R10: backpressure holds the result
        op_code = 4'd2; b_valid = 1; a_data = 8'd1; b_data = 8'd1; out_ready = 0;
        #1;
        chk(a_ready == 0, "R10 no accept", a_ready, 0);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            chk(out_valid && out_data == 8'd77, "R10 hold", out_data, 77);
        end
        out_ready = 1;
        #1;
        chk(a_ready == 1, "R10 release", a_ready, 1);
        @(posedge clk); @(negedge clk);
        chk(out_valid && out_data == 8'd2, "R10 refill", out_data, 2);

        // R1: drop A, result drains
        a_valid = 0; b_valid = 0;
        @(posedge clk); @(negedge clk);
        chk(out_valid == 0, "R1 empty", out_valid, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule